// File: doc/BRIEF.md
# Extended-Sequence Shift-Register Hybrid Counter

This block is a free-running synchronous up-counter meant for fast clock domains. Its low-order part is a small shift-register counter with linear feedback. A zero-detect term folded into that feedback adds the all-zero state to the cycle, so the low part steps through every one of its 2^m codes. Above it sits an ordinary n-bit binary counter. That counter is enabled only on the single step in each low-part period where the low part wraps, so it switches far less often than a flat binary counter of the same total width would.

The outputs are the raw shift-register code and the raw binary count. Mapping the shift-register code back to a binary number is left to the consumer. A terminal flag marks the final state of the full 2^(m+n) period. A synchronous reset starts both parts at zero. A count enable freezes the whole counter when it is low.

Top module: `hybrid_lfsr_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `low_state` becomes 0000, `high_count` becomes 0 and `tc` is 0.
- R2: With `en` high, each edge loads `low_state` with {s[2:0], f}, where f = s[3] XOR s[2] XOR (s[2:0]==000). This is the polynomial x^4+x^3+1 with the zero state inserted. From reset the sequence is 0000, 0001, 0010, 0100, 1001, 0011, 0110, 1101, 1010, 0101, 1011, 0111, 1111, 1110, 1100, 1000, and then it repeats.
- R3: `low_state` takes each of its 16 codes exactly once per low period. The first state is 0000 and the last is 1000.
- R4: `high_count` rises by exactly 1, modulo 2^n, on the edge where `en` is high and `low_state` leaves 1000. On every other edge it holds.
- R5: With `en` low, `low_state`, `high_count` and `tc` all keep their values.
- R6: `tc` is 1 exactly when `low_state` is 1000 and `high_count` is all ones. With `en` held high, it pulses for one cycle every 2^(m+n) = 256 cycles, first in cycle 255 after reset.
- R7: An enabled edge taken while `tc` is 1 returns both stages to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| low_state | output | LOW_W (4) | Raw code of the extended shift-register stage |
| high_count | output | HIGH_W (4) | Binary high-order count |
| tc | output | 1 | Final state of the full period |

## Verification
The embedded properties assume `rst` and `en` are synchronous levels that settle before each rising edge. They also assume the low stage holds a code reached from reset, because the wrap and zero-return checks rely on the registered last-state flag agreeing with the code. The bench changes inputs only on falling edges and always starts a scenario from reset. It never forces state, so every code it observes lies on the legal cycle.

// File: rtl/hlc_pkg.sv
package hlc_pkg;
   // Feedback tap mask for a left-shifting Fibonacci register of width w.
   // Bit w-1 is always set; the second tap selects a maximal polynomial.
   function automatic logic [7:0] tap_mask(input int w);
      logic [7:0] m;
      case (w)
         3: m = 8'b0000_0110;
         4: m = 8'b0000_1100;
         5: m = 8'b0001_0100;
         6: m = 8'b0011_0000;
         7: m = 8'b0110_0000;
         default: m = 8'b1011_1000;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/lfsr_ext_stage.sv
module lfsr_ext_stage
   import hlc_pkg::*;
#(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] state,
   output logic         at_last
);
   localparam logic [7:0]   MASK8 = tap_mask(W);
   localparam logic [W-1:0] TAPS  = MASK8[W-1:0];
   localparam logic [W-1:0] FIRST = '0;
   localparam logic [W-1:0] LAST  = W'(1) << (W-1);

   generate
      if (W < 3 || W > 8) begin : g_bad_width
         $error("lfsr_ext_stage: W must lie in 3..8");
      end
   endgenerate

   logic [W-1:0] state_q, state_d;
   logic         last_q;
   logic         zero_low;
   logic         fb;

   always_comb begin
      zero_low = (state_q[W-2:0] == '0);
      fb       = (^(state_q & TAPS)) ^ zero_low;
      state_d  = {state_q[W-2:0], fb};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= FIRST;
         last_q  <= 1'b0;
      end else if (adv) begin
         state_q <= state_d;
         last_q  <= (state_d == LAST);
      end
   end

   assign state   = state_q;
   assign at_last = last_q;

   // R7
   wrap_to_first_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && last_q) |=> (state_q == FIRST));
   // R5
   hold_low_chk: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(state_q));
   // R3
   last_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (last_q == (state_q == LAST)));
endmodule

// File: rtl/bin_high_stage.sv
module bin_high_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] count,
   output logic         all_ones
);
   generate
      if (W < 1) begin : g_bad_width
         $error("bin_high_stage: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)      cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + W'(1);
   end

   assign count    = cnt_q;
   assign all_ones = &cnt_q;

   // R4
   high_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt_q));
   // R4
   high_step_chk: assert property (@(posedge clk) disable iff (rst)
      inc |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/term_detect.sv
module term_detect (
   input  logic low_last,
   input  logic high_full,
   output logic tc
);
   assign tc = low_last & high_full;
endmodule

// File: rtl/hybrid_lfsr_counter.sv
module hybrid_lfsr_counter #(
   parameter int LOW_W  = 4,
   parameter int HIGH_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   output logic [LOW_W-1:0]  low_state,
   output logic [HIGH_W-1:0] high_count,
   output logic              tc
);
   localparam int TOTAL_W = LOW_W + HIGH_W;

   generate
      if (TOTAL_W > 30) begin : g_bad_total
         $error("hybrid_lfsr_counter: total width too large");
      end
   endgenerate

   logic low_last;
   logic high_full;
   logic high_inc;

   lfsr_ext_stage #(.W(LOW_W)) u_low (
      .clk     (clk),
      .rst     (rst),
      .adv     (en),
      .state   (low_state),
      .at_last (low_last)
   );

   // Registered wrap flag from the low stage acts as the high-stage enable.
   assign high_inc = en & low_last;

   bin_high_stage #(.W(HIGH_W)) u_high (
      .clk      (clk),
      .rst      (rst),
      .inc      (high_inc),
      .count    (high_count),
      .all_ones (high_full)
   );

   term_detect u_tc (
      .low_last  (low_last),
      .high_full (high_full),
      .tc        (tc)
   );

   // R7
   full_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (en && tc) |=> (low_state == '0 && high_count == '0));
   // R5
   tc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(tc));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (low_state == '0 && high_count == '0 && !tc));
endmodule

// File: tb/hybrid_lfsr_counter_tb.sv
module hybrid_lfsr_counter_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 4;
   localparam int HW = 4;
   localparam int LOW_N = 16;
   localparam int FULL_N = 256;
   localparam logic [LW-1:0] SEQ [LOW_N] = '{
      4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1001, 4'b0011, 4'b0110, 4'b1101,
      4'b1010, 4'b0101, 4'b1011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en  = 1'b0;
   logic [LW-1:0] low_state;
   logic [HW-1:0] high_count;
   logic tc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hybrid_lfsr_counter #(.LOW_W(LW), .HIGH_W(HW)) u_dut (
      .clk(clk), .rst(rst), .en(en),
      .low_state(low_state), .high_count(high_count), .tc(tc));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      en  = 1'b0;
      step();
      step();
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      check("R1 low", int'(low_state), 0);
      check("R1 high", int'(high_count), 0);
      check("R1 tc", int'(tc), 0);

      // R2 table walk over one low period
      en = 1'b1;
      for (int i = 0; i < LOW_N; i++) begin
         check("R2 low seq", int'(low_state), int'(SEQ[i]));
         check("R4 high before wrap", int'(high_count), 0);
         step();
      end
      check("R3 low back to first", int'(low_state), 0);
      check("R4 high after wrap", int'(high_count), 1);

      // R5 enable low freezes everything
      step(); step(); step();
      en = 1'b0;
      begin
         logic [LW-1:0] l0;
         logic [HW-1:0] h0;
         l0 = low_state;
         h0 = high_count;
         for (int k = 0; k < 5; k++) begin
            step();
            check("R5 low hold", int'(low_state), int'(l0));
            check("R5 high hold", int'(high_count), int'(h0));
         end
      end

      // R3 R4 R6 full period from reset
      do_reset();
      en = 1'b1;
      begin
         bit seen [LOW_N];
         int tc_cnt;
         int inc_cnt;
         logic [HW-1:0] prev_h;
         tc_cnt  = 0;
         inc_cnt = 0;
         prev_h  = '0;
         for (int k = 0; k < LOW_N; k++) seen[k] = 1'b0;
         for (int k = 0; k < FULL_N; k++) begin
            if (k % LOW_N == 0) begin
               for (int j = 0; j < LOW_N; j++) seen[j] = 1'b0;
            end
            check("R3 unique low", int'(seen[low_state]), 0);
            seen[low_state] = 1'b1;
            check("R2 low in period", int'(low_state), int'(SEQ[k % LOW_N]));
            check("R4 high in period", int'(high_count), k / LOW_N);
            check("R6 tc", int'(tc), (k == FULL_N - 1) ? 1 : 0);
            if (tc) tc_cnt++;
            if (high_count != prev_h) inc_cnt++;
            prev_h = high_count;
            step();
         end
         check("R6 one tc per period", tc_cnt, 1);
         check("R4 increments per period", inc_cnt, LOW_N - 1);
         // R7 both stages wrap to zero
         check("R7 low wrap", int'(low_state), 0);
         check("R7 high wrap", int'(high_count), 0);
         check("R7 tc clear", int'(tc), 0);
      end

      // R5 R7 hold at terminal state, then wrap
      do_reset();
      en = 1'b1;
      for (int k = 0; k < FULL_N - 1; k++) step();
      check("R6 tc at end", int'(tc), 1);
      en = 1'b0;
      step(); step();
      check("R5 tc held", int'(tc), 1);
      check("R5 low held at last", int'(low_state), 8);
      check("R5 high held at max", int'(high_count), 15);
      en = 1'b1;
      step();
      check("R7 low zero", int'(low_state), 0);
      check("R7 high zero", int'(high_count), 0);

      // R1 reset mid-count
      step(); step(); step();
      rst = 1'b1;
      step();
      check("R1 low mid reset", int'(low_state), 0);
      check("R1 high mid reset", int'(high_count), 0);
      rst = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule